// File: doc/BRIEF.md
# Majority-Minority Redundancy Voter with Error Flag

This block votes over NCOPY redundant copies of a WIDTH-bit function block. It needs fewer copies than a plain N-way majority vote for the same number of masked failures. Copies 0, 1 and 2 form a three-member primary group that is voted 2-of-3. The remaining NCOPY-3 copies form a secondary group. For each bit the block reduces the secondary group to either its AND or its OR, and the primary verdict picks which one.

The voted bit is the primary verdict ANDed with the chosen secondary value. A per-bit error is raised when the primary verdict is 1 and the chosen secondary value is 0. In that case the output disagrees with the primary group and cannot be trusted. The per-bit errors are ORed into one flag: 1 means the output is not dependable, 0 means no error was detected.

The voter is combinational. An output register stage is present when `REG_OUT` is 1 (the default). That stage has a synchronous active-high reset that clears all outputs to 0. Legal copy counts are 4 to 8. The three-of-five, three-of-six and three-of-seven setups mask up to 2, 3 and 4 failed copies respectively.

Top module: `cluster_voter`

## Requirements
- R1: Per bit, the primary verdict is 1 exactly when at least two of copies 0, 1 and 2 carry 1 in that bit.
- R2: When the primary verdict of a bit is 0, the voted bit is 0 and its per-bit error is 0, whatever the secondary copies carry.
- R3: When the primary verdict of a bit is 1, the voted bit equals the OR of that bit over copies 3 to NCOPY-1.
- R4: A per-bit error is 1 exactly when the primary verdict is 1 and every secondary copy carries 0 in that bit.
- R5: `err_o` is the OR of all WIDTH bits of `bit_err_o`.
- R6: When the primary verdict is 0 and every secondary copy carries 1, the voted bit is 0 and no error is flagged.
- R7: When the primary verdict is 1 and every secondary copy carries 0, the voted bit is 0 and the error flag is 1.
- R8: When at least two primary copies and at least one secondary copy hold the fault-free value, the voted bus equals that value and `err_o` is 0, for any faults on the other copies (up to NCOPY-3 failed copies).
- R9: With `REG_OUT`=1, outputs appear one clock after the inputs are sampled, and are unchanged before that edge. `rst` high at a rising edge clears `voted_o`, `bit_err_o` and `err_o` to 0.
- R10: Each output bit depends only on the same bit position of the copies. Different patterns in different lanes give independent per-lane results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output stage |
| rst | input | 1 | Synchronous active-high reset of the output stage |
| copies_i | input | NCOPY x WIDTH | Outputs of the redundant copies; index 0..2 primary, 3..NCOPY-1 secondary |
| voted_o | output | WIDTH | Voted result bus |
| bit_err_o | output | WIDTH | Per-bit not-dependable indication |
| err_o | output | 1 | OR of all per-bit errors |

## Verification
A wrong primary vote or a swapped AND/OR selection shows on `voted_o` one clock after the offending pattern is applied. It appears only for patterns where the primary copies disagree or the secondary copies are mixed. An exhaustive sweep of all copy patterns on a one-bit lane therefore exposes it within that sweep. A broken error path shows as a per-bit error that disagrees with the output, or as `err_o` disagreeing with the OR of `bit_err_o`, in the same cycle as the output. A lane wiring fault appears only when different lanes carry different patterns, which the per-lane stimulus provides.

// File: rtl/cv_pkg.sv
package cv_pkg;
  localparam int PRIMARY_COUNT = 3;
  localparam int MIN_COPIES    = 4;
  localparam int MAX_COPIES    = 8;

  function automatic logic vote_2of3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/cv_lane.sv
module cv_lane
  import cv_pkg::*;
#(
  parameter int NCOPY = 5,
  localparam int NSEC = NCOPY - PRIMARY_COUNT
) (
  input  logic [NCOPY-1:0] lane_i,
  output logic             vote_o,
  output logic             err_o
);
  logic            prim;
  logic            sec_all;
  logic            sec_any;
  logic            sec_pick;
  logic [NSEC-1:0] sec_bits;

  assign sec_bits = lane_i[NCOPY-1:PRIMARY_COUNT];
  assign prim     = vote_2of3(lane_i[0], lane_i[1], lane_i[2]);

  cv_sec_reduce #(.NSEC(NSEC)) u_sec (
    .bits_i (sec_bits),
    .all_o  (sec_all),
    .any_o  (sec_any)
  );

  assign sec_pick = prim ? sec_any : sec_all;
  assign vote_o   = prim & sec_pick;
  assign err_o    = prim & ~sec_pick;
endmodule

// File: rtl/cv_sec_reduce.sv
module cv_sec_reduce #(
  parameter int NSEC = 2
) (
  input  logic [NSEC-1:0] bits_i,
  output logic            all_o,
  output logic            any_o
);
  logic [NSEC-1:0] and_chain;
  logic [NSEC-1:0] or_chain;

  assign and_chain[0] = bits_i[0];
  assign or_chain[0]  = bits_i[0];
  for (genvar i = 1; i < NSEC; i++) begin : g_chain
    assign and_chain[i] = and_chain[i-1] & bits_i[i];
    assign or_chain[i]  = or_chain[i-1]  | bits_i[i];
  end

  assign all_o = and_chain[NSEC-1];
  assign any_o = or_chain[NSEC-1];
endmodule

// File: rtl/cv_out_stage.sv
module cv_out_stage #(
  parameter int WIDTH   = 8,
  parameter bit REG_OUT = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] vote_i,
  input  logic [WIDTH-1:0] bit_err_i,
  input  logic             err_i,
  output logic [WIDTH-1:0] vote_o,
  output logic [WIDTH-1:0] bit_err_o,
  output logic             err_o
);
  if (REG_OUT) begin : g_reg
    always_ff @(posedge clk) begin
      if (rst) begin
        vote_o    <= '0;
        bit_err_o <= '0;
        err_o     <= 1'b0;
      end else begin
        vote_o    <= vote_i;
        bit_err_o <= bit_err_i;
        err_o     <= err_i;
      end
    end
  end else begin : g_comb
    assign vote_o    = vote_i;
    assign bit_err_o = bit_err_i;
    assign err_o     = err_i;
  end
endmodule

// File: rtl/cluster_voter.sv
module cluster_voter
  import cv_pkg::*;
#(
  parameter int NCOPY   = 5,
  parameter int WIDTH   = 8,
  parameter bit REG_OUT = 1'b1,
  localparam int NSEC   = NCOPY - PRIMARY_COUNT
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [NCOPY-1:0][WIDTH-1:0] copies_i,
  output logic [WIDTH-1:0]            voted_o,
  output logic [WIDTH-1:0]            bit_err_o,
  output logic                        err_o
);
  if (NCOPY < MIN_COPIES || NCOPY > MAX_COPIES) begin : g_bad_ncopy
    $error("cluster_voter: NCOPY out of range 4..8");
  end

  logic [WIDTH-1:0][NCOPY-1:0] lane_w;
  logic [WIDTH-1:0]            vote_c;
  logic [WIDTH-1:0]            bit_err_c;
  logic                        err_c;

  for (genvar b = 0; b < WIDTH; b++) begin : g_lane
    for (genvar k = 0; k < NCOPY; k++) begin : g_tap
      assign lane_w[b][k] = copies_i[k][b];
    end

    cv_lane #(.NCOPY(NCOPY)) u_lane (
      .lane_i (lane_w[b]),
      .vote_o (vote_c[b]),
      .err_o  (bit_err_c[b])
    );

    // R2: a lost primary vote never lets a 1 through
    p_low_prim_r2: assert property (@(posedge clk) disable iff (rst)
      ($countones(lane_w[b][PRIMARY_COUNT-1:0]) < 2) |-> (!vote_c[b] && !bit_err_c[b]));

    // R3: a won primary vote passes any secondary 1
    p_high_prim_r3: assert property (@(posedge clk) disable iff (rst)
      (($countones(lane_w[b][PRIMARY_COUNT-1:0]) >= 2) &&
       ($countones(lane_w[b][NCOPY-1:PRIMARY_COUNT]) > 0)) |-> vote_c[b]);

    // R4: an error bit means every secondary copy said 0
    p_err_sec_r4: assert property (@(posedge clk) disable iff (rst)
      bit_err_c[b] |-> ($countones(lane_w[b][NCOPY-1:PRIMARY_COUNT]) == 0));
  end

  cv_err_reduce #(.WIDTH(WIDTH)) u_err (
    .bits_i (bit_err_c),
    .any_o  (err_c)
  );

  cv_out_stage #(.WIDTH(WIDTH), .REG_OUT(REG_OUT)) u_out (
    .clk       (clk),
    .rst       (rst),
    .vote_i    (vote_c),
    .bit_err_i (bit_err_c),
    .err_i     (err_c),
    .vote_o    (voted_o),
    .bit_err_o (bit_err_o),
    .err_o     (err_o)
  );

  // R5: combined flag agrees with the per-bit vector at the ports
  p_err_or_r5: assert property (@(posedge clk) disable iff (rst)
    err_o == (|bit_err_o));

  if (REG_OUT) begin : g_lat_chk
    // R9: registered outputs carry last cycle's vote
    p_reg_vote_r9: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> (voted_o == $past(vote_c)) && (bit_err_o == $past(bit_err_c)));
  end
endmodule

// File: rtl/cv_err_reduce.sv
module cv_err_reduce #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] bits_i,
  output logic             any_o
);
  logic [WIDTH-1:0] acc;

  assign acc[0] = bits_i[0];
  for (genvar i = 1; i < WIDTH; i++) begin : g_or
    assign acc[i] = acc[i-1] | bits_i[i];
  end
  assign any_o = acc[WIDTH-1];
endmodule

// File: tb/tb_cluster_voter.sv
`timescale 1ns/1ps
module tb_cluster_voter;
  localparam int NC = 5;
  localparam int W  = 8;
  localparam int NX = 7;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [NC-1:0][W-1:0] copies;
  logic [W-1:0]         voted, bit_err;
  logic                 err;
  logic [NX-1:0][0:0]   xcopies;
  logic [0:0]           xvoted, xbit_err;
  logic                 xerr;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  cluster_voter #(.NCOPY(NC), .WIDTH(W)) dut (
    .clk(clk), .rst(rst), .copies_i(copies),
    .voted_o(voted), .bit_err_o(bit_err), .err_o(err));

  cluster_voter #(.NCOPY(NX), .WIDTH(1)) dut_x (
    .clk(clk), .rst(rst), .copies_i(xcopies),
    .voted_o(xvoted), .bit_err_o(xbit_err), .err_o(xerr));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // reference per-bit model from the requirements
  function automatic logic [1:0] ref_bit(input logic [7:0] bits, input int m);
    int  ones = 0;
    logic all1 = 1'b1, any1 = 1'b0, prim, pick;
    for (int k = 0; k < 3; k++) ones += bits[k];
    for (int k = 3; k < m; k++) begin
      all1 &= bits[k];
      any1 |= bits[k];
    end
    prim = (ones >= 2);
    pick = prim ? any1 : all1;
    return {prim & ~pick, prim & pick};
  endfunction

  task automatic drive_main(input logic [NC-1:0][W-1:0] v);
    @(negedge clk); copies = v;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R9 reset voted", voted, 0);
    chk("R9 reset bit_err", bit_err, 0);
    chk("R9 reset err", err, 0);
  endtask

  task automatic t_exhaustive;
    for (int p = 0; p < (1 << NX); p++) begin
      logic [1:0] e;
      @(negedge clk);
      for (int k = 0; k < NX; k++) xcopies[k] = p[k];
      @(negedge clk);
      e = ref_bit(8'(p), NX);
      chk("R1/R2/R3 vote", xvoted, e[0]);
      chk("R4 bit error", xbit_err, e[1]);
      chk("R5 flag", xerr, e[1]);
    end
  endtask

  task automatic t_sec_all_one_r6;
    logic [NC-1:0][W-1:0] v;
    v[0] = 8'h00; v[1] = 8'h00; v[2] = 8'hFF; v[3] = 8'hFF; v[4] = 8'hFF;
    drive_main(v);
    chk("R6 voted", voted, 0);
    chk("R6 err", err, 0);
  endtask

  task automatic t_sec_all_zero_r7;
    logic [NC-1:0][W-1:0] v;
    v[0] = 8'hFF; v[1] = 8'h00; v[2] = 8'hFF; v[3] = 8'h00; v[4] = 8'h00;
    drive_main(v);
    chk("R7 voted", voted, 0);
    chk("R7 bit_err", bit_err, 8'hFF);
    chk("R7 err", err, 1);
  endtask

  task automatic t_mult_faults_r8;
    logic [31:0] lfsr = 32'h1234_5678;
    for (int n = 0; n < 40; n++) begin
      logic [3:0] a, b;
      logic [7:0] good;
      logic [NC-1:0][W-1:0] v;
      int fp, fs;
      lfsr = lfsr * 32'd1664525 + 32'd1013904223;
      a = lfsr[7:4]; b = lfsr[11:8];
      good = 8'(a) * 8'(b);
      for (int k = 0; k < NC; k++) v[k] = good;
      fp = n % 3;
      fs = 3 + (n % 2);
      v[fp] = (n % 4 == 0) ? 8'h00 : (n % 4 == 1) ? 8'hFF : lfsr[23:16];
      v[fs] = (n % 4 == 2) ? 8'h00 : (n % 4 == 3) ? 8'hFF : lfsr[31:24];
      drive_main(v);
      chk("R8 masked product", voted, good);
      chk("R8 no error", err, 0);
    end
  endtask

  task automatic t_lanes_r10;
    for (int s = 0; s < 32; s++) begin
      logic [NC-1:0][W-1:0] v;
      logic [W-1:0] ev, ee;
      for (int b = 0; b < W; b++) begin
        logic [7:0] pat = 8'((s * 7 + b * 13) & 31);
        logic [1:0] e = ref_bit(pat, NC);
        for (int k = 0; k < NC; k++) v[k][b] = pat[k];
        ev[b] = e[0]; ee[b] = e[1];
      end
      drive_main(v);
      chk("R10 lane vote", voted, ev);
      chk("R10 lane bit_err", bit_err, ee);
      chk("R5 flag is OR", err, |ee);
    end
  endtask

  task automatic t_latency_r9;
    logic [NC-1:0][W-1:0] v;
    for (int k = 0; k < NC; k++) v[k] = 8'h00;
    drive_main(v);
    for (int k = 0; k < NC; k++) v[k] = 8'hA5;
    @(negedge clk); copies = v;
    #1;
    chk("R9 before edge", voted, 8'h00);
    @(negedge clk);
    chk("R9 after one edge", voted, 8'hA5);
    rst = 1'b1;
    @(negedge clk);
    chk("R9 sync reset voted", voted, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R9 after reset release", voted, 8'hA5);
  endtask

  initial begin
    copies  = '0;
    xcopies = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst = 1'b0;
    t_exhaustive();
    t_sec_all_one_r6();
    t_sec_all_zero_r7();
    t_mult_faults_r8();
    t_lanes_r10();
    t_latency_r9();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(5.0 * 100000);
    if (!done) begin
      done = 1'b1;
      total++;
      bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule